// File: doc/BRIEF.md
# Dual Edge Event Counter

This block counts transitions on two asynchronous event inputs. Each input passes through a two-flop synchronizer and an edge detector; a per-channel polarity bit decides whether rising or falling transitions are counted. Each channel owns a 16-bit counter that wraps to zero past its maximum value.

A cascade option joins the two counters into a single 32-bit counter. The first channel forms the low half and the second channel forms the high half. Only the first input advances the counter, and the second input has no effect. Software reaches the block through a byte-wide register port. A control byte holds the two polarity bits, the cascade bit and a snapshot bit. When the snapshot bit is set, all four count bytes are frozen for reading while counting goes on underneath. Writing a count byte presets that byte. Any register write blocks counting for that cycle, and an edge that falls in the blocked cycle is lost.

Top module: `evc_top`

## Requirements
- R1: While reset is low, both counters clear to zero and the control byte at address 0x0C clears to 0x00. After reset, all five registers (0x0C to 0x10) read back as zero.
- R2: With polarity bit 0 of the control byte at 0 (channel A) or bit 1 at 0 (channel B), a 0-to-1 transition on the input adds one to that channel's counter, and a 1-to-0 transition adds nothing.
- R3: With the polarity bit of a channel at 1, a 1-to-0 transition adds one, and a 0-to-1 transition adds nothing.
- R4: With cascade (control bit 2) clear, transitions on input A change only counter A (bytes 0x0D low, 0x0E high), and transitions on input B change only counter B (bytes 0x0F low, 0x10 high).
- R5: With cascade clear, a counter at 0xFFFF that counts an event becomes 0x0000, and the other counter does not change.
- R6: With cascade set, counter A is the low half and counter B the high half of one 32-bit value. Only input A advances it, a step from 0xFFFF in A carries into B, and transitions on input B change nothing.
- R7: Writing one count byte replaces that byte alone. The other byte of the same counter keeps its value.
- R8: An edge whose count would land in a cycle in which any register write is active is dropped. An edge whose count lands in any other cycle near that write is counted.
- R9: Writing the control byte with the snapshot bit (bit 3) going from 0 to 1 captures all four count bytes. While the bit stays set, count reads return the captured values. Once it is cleared, reads return the live counts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe, one byte per cycle |
| reg_addr_i | input | ADDR_W (5) | Register address for both read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| evt_a_i | input | 1 | Event input for channel A, asynchronous |
| evt_b_i | input | 1 | Event input for channel B, asynchronous |

## Verification
Two functions can meet in a single clock cycle. One is a register write, which presets or reconfigures the block. The other is the increment from a synchronized edge. The bench raises input A and then starts a single control write at each of five offsets from zero to four cycles later. Because the input takes three registers to reach the counter, only the write whose active edge matches the counting edge should make the event vanish. Each offset is judged by reading the counter back and comparing it with the previous value, plus one for every offset except the colliding one.

// File: rtl/evc_pkg.sv
// Package: shared types and constants for the dual edge event counter.
// Assumes a byte-wide register port; the control byte layout is fixed here.
package evc_pkg;

    localparam int CTRL_BITS = 4;
    localparam int POL_A_BIT = 0;
    localparam int POL_B_BIT = 1;
    localparam int CASC_BIT  = 2;
    localparam int SNAP_BIT  = 3;

    // Control byte, MSB first: snapshot, cascade, polarity B, polarity A
    typedef struct packed {
        logic snap;
        logic cascade;
        logic pol_b;
        logic pol_a;
    } evc_ctrl_t;

endpackage

// File: rtl/evc_edge_det.sv
// Module: synchronizes one asynchronous input and emits a one-cycle pulse
// on the transition selected by pol_i (0 = rising, 1 = falling).
// Assumes the input is low during reset. Latency: a change seen before
// clock edge 1 produces a pulse between edges SYNC_STAGES and SYNC_STAGES+1.
module evc_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    output logic pulse_o
);

    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] shreg;
    logic             now_lvl;
    logic             old_lvl;

    // Shift the pin through the synchronizer and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[DEPTH-2:0], pin_i};
        end
    end

    assign now_lvl = shreg[SYNC_STAGES-1];
    assign old_lvl = shreg[SYNC_STAGES];

    // Select rising or falling transition by polarity
    always_comb begin
        if (pol_i) begin
            pulse_o = old_lvl & ~now_lvl;
        end else begin
            pulse_o = ~old_lvl & now_lvl;
        end
    end

endmodule

// File: rtl/evc_counter.sv
// Module: one W-bit event counter with per-byte preset.
// Assumes W is a multiple of 8 and that inc_i is already gated against
// register writes; a byte write takes priority over the increment.
module evc_counter #(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_i,
    input  logic [W/8-1:0]  wr_sel_i,
    input  logic [7:0]      wr_data_i,
    output logic [W-1:0]    cnt_o
);

    localparam int NB = W / 8;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;

    // Next value: increment, then overlay any byte that is written
    always_comb begin
        cnt_nxt = cnt_q;
        if (inc_i) begin
            cnt_nxt = cnt_q + W'(1);
        end
        for (int b = 0; b < NB; b++) begin
            if (wr_sel_i[b]) begin
                cnt_nxt[b*8 +: 8] = wr_data_i;
            end
        end
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/evc_regif.sv
// Module: register port for the event counter. It decodes byte writes,
// holds the control byte, takes the snapshot on a 0-to-1 write of the
// snapshot bit and muxes read data. Assumes the counter bytes follow the
// control byte at consecutive addresses, low byte of counter A first.
module evc_regif
    import evc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [7:0]            wdata_i,
    input  logic [2*CNT_W-1:0]    live_i,
    output evc_ctrl_t             ctrl_o,
    output logic [2*CNT_W/8-1:0]  cnt_wsel_o,
    output logic [2*CNT_W-1:0]    snap_o,
    output logic [7:0]            rdata_o
);

    localparam int NREG = 2 * CNT_W / 8;

    evc_ctrl_t          ctrl_q;
    logic [2*CNT_W-1:0] snap_q;
    logic [2*CNT_W-1:0] rd_src;
    logic               ctrl_wr;
    logic               snap_take;

    assign ctrl_wr   = wr_i && (addr_i == ADDR_W'(CTRL_ADDR));
    assign snap_take = ctrl_wr && wdata_i[SNAP_BIT] && !ctrl_q.snap;

    // Byte write strobes for the counter bytes
    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            cnt_wsel_o[k] = wr_i && (addr_i == ADDR_W'(CTRL_ADDR + 1 + k));
        end
    end

    // Control byte register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= evc_ctrl_t'(wdata_i[CTRL_BITS-1:0]);
        end
    end

    // Snapshot capture on the rising write of the snapshot bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (snap_take) begin
            snap_q <= live_i;
        end
    end

    assign rd_src = ctrl_q.snap ? snap_q : live_i;

    // Read mux over the control byte and the count bytes
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(CTRL_ADDR)) begin
            rdata_o = {{(8 - CTRL_BITS){1'b0}}, ctrl_q};
        end
        for (int k = 0; k < NREG; k++) begin
            if (addr_i == ADDR_W'(CTRL_ADDR + 1 + k)) begin
                rdata_o = rd_src[k*8 +: 8];
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign snap_o = snap_q;

endmodule

// File: rtl/evc_top.sv
// Module: dual edge event counter top. Two synchronized edge detectors feed
// two counters. In cascade mode, counter B counts carries out of counter A.
// Any register write blocks counting in its cycle, and such edges are lost.
module evc_top
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 5,
    parameter int CTRL_ADDR   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic              evt_a_i,
    input  logic              evt_b_i
);

    localparam int NB = CNT_W / 8;

    evc_ctrl_t           ctrl;
    logic [1:0]          pins;
    logic [1:0]          pols;
    logic [1:0]          pulse;
    logic [1:0]          inc;
    logic [2*NB-1:0]     wsel;
    logic [CNT_W-1:0]    cnt_arr [2];
    logic [CNT_W-1:0]    cnt_a;
    logic [CNT_W-1:0]    cnt_b;
    logic [2*CNT_W-1:0]  snap_word;
    logic                inc_a;
    logic                inc_b;
    logic                carry_a;
    logic                ctrl_rc;
    logic                ctrl_casc;

    assign pins = {evt_b_i, evt_a_i};
    assign pols = {ctrl.pol_b, ctrl.pol_a};

    // One detector and one counter per channel
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        evc_edge_det #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pins[ch]),
            .pol_i   (pols[ch]),
            .pulse_o (pulse[ch])
        );

        evc_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc[ch]),
            .wr_sel_i  (wsel[ch*NB +: NB]),
            .wr_data_i (reg_wdata_i),
            .cnt_o     (cnt_arr[ch])
        );
    end

    assign cnt_a = cnt_arr[0];
    assign cnt_b = cnt_arr[1];

    // Increment steering: write blocking and cascade carry
    always_comb begin
        inc_a   = pulse[0] && !reg_wr_i;
        carry_a = inc_a && (cnt_a == {CNT_W{1'b1}});
        inc_b   = ctrl.cascade ? carry_a : (pulse[1] && !reg_wr_i);
    end

    assign inc       = {inc_b, inc_a};
    assign ctrl_rc   = ctrl.snap;
    assign ctrl_casc = ctrl.cascade;

    evc_regif #(
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .live_i     ({cnt_b, cnt_a}),
        .ctrl_o     (ctrl),
        .cnt_wsel_o (wsel),
        .snap_o     (snap_word),
        .rdata_o    (reg_rdata_o)
    );

endmodule

// File: rtl/evc_checker.sv
// Module: temporal checks on the event counter, bound into evc_top.
// Assumes the internal count, snapshot and control signals of the top.
module evc_checker #(
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [CNT_W-1:0]     cnt_a,
    input logic [CNT_W-1:0]     cnt_b,
    input logic [2*CNT_W-1:0]   snap_word,
    input logic                 ctrl_rc,
    input logic                 ctrl_casc
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt_a == '0 && cnt_b == '0 && !ctrl_rc));

    // R5
    step_or_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> (cnt_a == $past(cnt_a) || cnt_a == CNT_W'($past(cnt_a) + 1)));

    // R6
    cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_casc && !reg_wr_i && cnt_a != {CNT_W{1'b1}}) |=> $stable(cnt_b));

    // R8
    write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(CTRL_ADDR)) |=> ($stable(cnt_a) && $stable(cnt_b)));

    // R9
    snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rc && !(reg_wr_i && reg_addr_i == ADDR_W'(CTRL_ADDR))) |=> $stable(snap_word));

endmodule

bind evc_top evc_checker #(
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_evc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .cnt_a      (cnt_a),
    .cnt_b      (cnt_b),
    .snap_word  (snap_word),
    .ctrl_rc    (ctrl_rc),
    .ctrl_casc  (ctrl_casc)
);

// File: tb/evc_top_bench.sv
// Bench: directed sweeps over the event counter with arithmetic expectations.
module evc_top_bench;

    localparam logic [4:0] A_CTRL = 5'h0C;
    localparam logic [4:0] A_ALO  = 5'h0D;
    localparam logic [4:0] A_AHI  = 5'h0E;
    localparam logic [4:0] A_BLO  = 5'h0F;
    localparam logic [4:0] A_BHI  = 5'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       evt_a = 1'b0;
    logic       evt_b = 1'b0;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    evc_top u_evc_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .evt_a_i     (evt_a),
        .evt_b_i     (evt_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd16(input logic [4:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 5'd1, h);
        v = {h, l};
    endtask

    task automatic set16(input logic [4:0] lo, input logic [15:0] v);
        wr(lo, v[7:0]);
        wr(lo + 5'd1, v[15:8]);
    endtask

    task automatic drive_a(input logic v);
        @(negedge clk);
        evt_a = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic drive_b(input logic v);
        @(negedge clk);
        evt_b = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b8;
        logic [15:0] va, vb, base;
        logic [31:0] v32;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all registers
        for (int a = 12; a <= 16; a++) begin
            rd(5'(a), b8);
            chk($sformatf("R1 reg %0h after reset", a), {24'h0, b8}, 32'h0);
        end

        // R2: rising edges count, falling edges do not, on both channels
        for (int n = 1; n <= 5; n++) begin
            drive_a(1'b1);
            rd16(A_ALO, va);
            chk($sformatf("R2 A rise %0d", n), {16'h0, va}, 32'(n));
            drive_a(1'b0);
            rd16(A_ALO, va);
            chk($sformatf("R2 A fall %0d ignored", n), {16'h0, va}, 32'(n));
        end

        // R4: input B only moves counter B while cascade is clear
        for (int n = 1; n <= 4; n++) begin
            drive_b(1'b1);
            drive_b(1'b0);
            rd16(A_BLO, vb);
            chk($sformatf("R4 B count %0d", n), {16'h0, vb}, 32'(n));
            rd16(A_ALO, va);
            chk("R4 A untouched by B", {16'h0, va}, 32'd5);
        end

        // R7: single byte writes leave the other byte alone
        set16(A_ALO, 16'h1234);
        wr(A_ALO, 8'h9A);
        rd16(A_ALO, va);
        chk("R7 low byte write", {16'h0, va}, 32'h129A);
        wr(A_AHI, 8'hC5);
        rd16(A_ALO, va);
        chk("R7 high byte write", {16'h0, va}, 32'hC59A);

        // R5: wrap of counter A and of counter B, no carry across
        set16(A_ALO, 16'hFFFE);
        set16(A_BLO, 16'h0042);
        for (int n = 1; n <= 3; n++) begin
            drive_a(1'b1);
            drive_a(1'b0);
            rd16(A_ALO, va);
            chk($sformatf("R5 A wrap step %0d", n), {16'h0, va}, 32'(16'(16'hFFFE + n)));
        end
        rd16(A_BLO, vb);
        chk("R5 B unchanged by A wrap", {16'h0, vb}, 32'h0042);
        set16(A_BLO, 16'hFFFF);
        drive_b(1'b1);
        drive_b(1'b0);
        rd16(A_BLO, vb);
        chk("R5 B wrap", {16'h0, vb}, 32'h0);

        // R3: falling polarity on each channel
        wr(A_CTRL, 8'h03);
        set16(A_ALO, 16'h0000);
        set16(A_BLO, 16'h0000);
        for (int n = 1; n <= 3; n++) begin
            drive_a(1'b1);
            drive_b(1'b1);
            rd16(A_ALO, va);
            chk($sformatf("R3 A rise %0d ignored", n), {16'h0, va}, 32'(n - 1));
            drive_a(1'b0);
            drive_b(1'b0);
            rd16(A_ALO, va);
            chk($sformatf("R3 A fall %0d", n), {16'h0, va}, 32'(n));
            rd16(A_BLO, vb);
            chk($sformatf("R3 B fall %0d", n), {16'h0, vb}, 32'(n));
        end
        wr(A_CTRL, 8'h00);

        // R8: sweep write offset against one rising edge on A
        for (int k = 0; k <= 4; k++) begin
            rd16(A_ALO, base);
            @(negedge clk);
            evt_a = 1'b1;
            repeat (k) @(negedge clk);
            reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 8'h00;
            @(negedge clk);
            reg_wr = 1'b0;
            repeat (4) @(negedge clk);
            drive_a(1'b0);
            rd16(A_ALO, va);
            chk($sformatf("R8 write offset %0d", k), {16'h0, va},
                32'(16'(base + ((k == 2) ? 16'd0 : 16'd1))));
        end

        // R6: cascade carry, then B input ignored
        wr(A_CTRL, 8'h04);
        set16(A_ALO, 16'hFFFD);
        set16(A_BLO, 16'h0010);
        for (int n = 1; n <= 5; n++) begin
            drive_a(1'b1);
            drive_a(1'b0);
            rd16(A_ALO, va);
            rd16(A_BLO, vb);
            chk($sformatf("R6 cascade step %0d", n), {vb, va}, 32'h0010_FFFD + 32'(n));
        end
        v32 = {vb, va};
        for (int n = 1; n <= 2; n++) begin
            drive_b(1'b1);
            drive_b(1'b0);
            rd16(A_ALO, va);
            rd16(A_BLO, vb);
            chk($sformatf("R6 B ignored %0d", n), {vb, va}, v32);
        end
        wr(A_CTRL, 8'h00);

        // R9: snapshot freezes reads, live values return after clear
        set16(A_ALO, 16'h0100);
        set16(A_BLO, 16'h0200);
        wr(A_CTRL, 8'h08);
        for (int n = 1; n <= 3; n++) begin
            drive_a(1'b1);
            drive_b(1'b1);
            drive_a(1'b0);
            drive_b(1'b0);
        end
        rd16(A_ALO, va);
        chk("R9 snapshot A frozen", {16'h0, va}, 32'h0100);
        rd16(A_BLO, vb);
        chk("R9 snapshot B frozen", {16'h0, vb}, 32'h0200);
        wr(A_CTRL, 8'h00);
        rd16(A_ALO, va);
        chk("R9 live A after clear", {16'h0, va}, 32'h0103);
        rd16(A_BLO, vb);
        chk("R9 live B after clear", {16'h0, vb}, 32'h0203);
        wr(A_CTRL, 8'h08);
        drive_a(1'b1);
        drive_a(1'b0);
        rd16(A_ALO, va);
        chk("R9 second snapshot", {16'h0, va}, 32'h0103);
        wr(A_CTRL, 8'h00);
        rd16(A_ALO, va);
        chk("R9 live after second clear", {16'h0, va}, 32'h0104);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule